// File: doc/BRIEF.md
# Multicycle Processor Step Controller

This block is the hardwired sequencing logic of a non-pipelined processor. Each instruction goes through five steps: fetch, decode, execute, memory access and writeback. The current step is held in a one-hot register. A fetch may last several cycles, because the unit waits in fetch until the memory subsystem signals that the instruction word is valid. After writeback the unit returns to fetch for the next instruction.

An external decoder supplies one class flag per instruction class: ALU, load, store, branch and call. It also supplies a branch-taken flag. Each strobe and select is formed as a fixed Boolean product of one step bit and one class flag. These outputs drive the register-file write port, the memory read and write strobes, the load enables of the instruction register and the program counter, the multiplexers that pick the next PC, the ALU second operand, the memory address and the writeback value, and a small ALU operation code.

If more than one class flag is high, the instruction is treated as illegal. It produces no class-dependent control, and the unit still steps through the full sequence.

Top module: `mcc_control_unit`

## Requirements
- R1: `stepOut` is one-hot. The bit order is fetch=bit0, decode=bit1, execute=bit2, memory=bit3 and writeback=bit4. The unit advances one bit per clock from decode to writeback, and from writeback it returns to fetch.
- R2: In fetch, the step holds while `memDone` is low and moves to decode on the clock where `memDone` is high. `irLoadEn` is high only in fetch while `memDone` is high.
- R3: A synchronous active-high `rst` puts the step in fetch (`stepOut`=00001) at the next edge. While `rst` is high, every output except `stepOut` is 0.
- R4: `rfWrEn` is high only in writeback, and only for a legal ALU, load or call instruction. It is never high for a store or a branch.
- R5: `memRdEn` is high throughout fetch, whether or not `memDone` is high. It is also high in the memory step of a legal load, and low everywhere else.
- R6: `memWrEn` is high only in the memory step of a legal store. A store raises no output in writeback.
- R7: `pcLoadEn` is high in fetch when `memDone` is high, with `pcSrcSel`=0 (incremented PC). It is also high in execute for a legal taken branch or a legal call. `pcSrcSel` is 1 (target) in execute for any legal branch or call.
- R8: In execute, `aluOp` is 2 (the instruction's own function) for ALU instructions, with `bImmSel`=0 (register). `aluOp` is 1 (add) for load, store, branch and call. `bImmSel` is 1 (immediate) for load and store.
- R9: `maddrSel` is 1 (ALU result as address) in the memory step of a legal load or store, and 0 elsewhere (PC as address).
- R10: In the memory step, `wbLatchEn` is 1 for a legal ALU, load or call instruction. `wbSel` is 0 (ALU result) for ALU, 1 (memory data) for load and 2 (return address) for call. An ALU instruction makes no memory access.
- R11: When two or more class flags are high, `rfWrEn`, `memWrEn`, `wbLatchEn`, execute-step `pcLoadEn`, memory-step `memRdEn`, and all selects and `aluOp` stay 0. The step sequence is unchanged.
- R12: In decode, and in every step where a select or `aluOp` is not named above, that output is 0. With no class flag high, only the fetch outputs ever rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| isAlu | input | 1 | Decoded class flag: register ALU operation |
| isLoad | input | 1 | Decoded class flag: load |
| isStore | input | 1 | Decoded class flag: store |
| isBranch | input | 1 | Decoded class flag: conditional branch |
| isCall | input | 1 | Decoded class flag: call (writes link register) |
| brTaken | input | 1 | Branch condition is true |
| memDone | input | 1 | Memory transfer complete, data valid |
| stepOut | output | 5 | One-hot current step |
| rfWrEn | output | 1 | Register-file write enable |
| memRdEn | output | 1 | Memory read strobe |
| memWrEn | output | 1 | Memory write strobe |
| irLoadEn | output | 1 | Instruction register load enable |
| pcLoadEn | output | 1 | Program counter load enable |
| pcSrcSel | output | 1 | Next-PC select: 0 incremented, 1 target |
| bImmSel | output | 1 | ALU second operand: 0 register, 1 immediate |
| maddrSel | output | 1 | Memory address: 0 PC, 1 ALU result |
| wbLatchEn | output | 1 | Load enable of the writeback value register |
| wbSel | output | 2 | Writeback value: 0 ALU, 1 memory data, 2 return address |
| aluOp | output | 2 | ALU operation: 0 idle, 1 add, 2 instruction function |

## Verification
The step register is the only state in the block. If it is wrong, it shows on `stepOut` at once. Within the same cycle it also gives the wrong strobe set: for example, a missed fetch hold drops `irLoadEn` while a memory read is still pending. A stuck or doubled step bit breaks the one-hot pattern and the fixed five-step order by the next edge. A wrong class product shows as a misplaced write strobe in the step where that class should be silent, so each class is walked through all five steps. The illegal and empty class patterns are walked as well.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int NUM_STEPS = 5;
  localparam int NUM_CLASS = 5;
  localparam int WBSEL_W = 2;
  localparam int ALUOP_W = 2;

  localparam int ST_FETCH = 0;
  localparam int ST_DECODE = 1;
  localparam int ST_EXEC = 2;
  localparam int ST_MEM = 3;
  localparam int ST_WB = 4;

  localparam int CL_ALU = 0;
  localparam int CL_LOAD = 1;
  localparam int CL_STORE = 2;
  localparam int CL_BRANCH = 3;
  localparam int CL_CALL = 4;

  localparam logic [WBSEL_W-1:0] WB_ALU = 2'd0;
  localparam logic [WBSEL_W-1:0] WB_MEM = 2'd1;
  localparam logic [WBSEL_W-1:0] WB_LINK = 2'd2;

  localparam logic [ALUOP_W-1:0] OP_IDLE = 2'd0;
  localparam logic [ALUOP_W-1:0] OP_ADD = 2'd1;
  localparam logic [ALUOP_W-1:0] OP_FUNC = 2'd2;

  typedef logic [NUM_STEPS-1:0] step_t;
  typedef logic [NUM_CLASS-1:0] class_t;

  typedef struct packed {
    logic rfWr;
    logic memRd;
    logic memWr;
    logic irLoad;
    logic pcLoad;
    logic pcSrc;
    logic bImm;
    logic maddr;
    logic wbLatch;
    logic [WBSEL_W-1:0] wbSel;
    logic [ALUOP_W-1:0] aluOp;
  } ctrlStrobes_t;
endpackage

// File: rtl/mcc_step_seq.sv
module mcc_step_seq
  import mcc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  memDone,
  output step_t stepQ
);
  step_t stepNxt;
  logic advance;

  // Fetch waits for the memory handshake; every other step lasts one cycle.
  assign advance = !stepQ[ST_FETCH] || memDone;

  for (genvar i = 0; i < NUM_STEPS; i++) begin : g_ring
    localparam int PREV = (i == 0) ? NUM_STEPS - 1 : i - 1;
    assign stepNxt[i] = advance ? stepQ[PREV] : stepQ[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stepQ <= step_t'(1) << ST_FETCH;
    end else begin
      stepQ <= stepNxt;
    end
  end
endmodule

// File: rtl/mcc_class_check.sv
module mcc_class_check
  import mcc_pkg::*;
(
  input  class_t rawClass,
  output class_t qualClass,
  output logic   illegal
);
  localparam int CNT_W = $clog2(NUM_CLASS + 1);
  logic [CNT_W-1:0] hot;

  always_comb begin
    hot = '0;
    for (int i = 0; i < NUM_CLASS; i++) begin
      hot = hot + CNT_W'(rawClass[i]);
    end
  end

  assign illegal = (hot > CNT_W'(1));
  assign qualClass = illegal ? '0 : rawClass;
endmodule

// File: rtl/mcc_strobe_gen.sv
module mcc_strobe_gen
  import mcc_pkg::*;
(
  input  step_t        step,
  input  class_t       cls,
  input  logic         brTaken,
  input  logic         memDone,
  output ctrlStrobes_t strb
);
  logic fe, ex, me, wb;
  logic producesValue, usesImm, pcRedirect;

  assign fe = step[ST_FETCH];
  assign ex = step[ST_EXEC];
  assign me = step[ST_MEM];
  assign wb = step[ST_WB];

  assign producesValue = cls[CL_ALU] | cls[CL_LOAD] | cls[CL_CALL];
  assign usesImm = cls[CL_LOAD] | cls[CL_STORE];
  assign pcRedirect = cls[CL_BRANCH] | cls[CL_CALL];

  always_comb begin
    strb = '0;
    strb.rfWr = wb & producesValue;
    strb.memRd = fe | (me & cls[CL_LOAD]);
    strb.memWr = me & cls[CL_STORE];
    strb.irLoad = fe & memDone;
    strb.pcLoad = (fe & memDone)
                | (ex & ((cls[CL_BRANCH] & brTaken) | cls[CL_CALL]));
    strb.pcSrc = ex & pcRedirect;
    strb.bImm = ex & usesImm;
    strb.maddr = me & usesImm;
    strb.wbLatch = me & producesValue;
    if (me & cls[CL_LOAD]) begin
      strb.wbSel = WB_MEM;
    end else if (me & cls[CL_CALL]) begin
      strb.wbSel = WB_LINK;
    end else begin
      strb.wbSel = WB_ALU;
    end
    if (ex & cls[CL_ALU]) begin
      strb.aluOp = OP_FUNC;
    end else if (ex & (usesImm | pcRedirect)) begin
      strb.aluOp = OP_ADD;
    end else begin
      strb.aluOp = OP_IDLE;
    end
  end
endmodule

// File: rtl/mcc_control_unit.sv
module mcc_control_unit
  import mcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       isAlu,
  input  logic       isLoad,
  input  logic       isStore,
  input  logic       isBranch,
  input  logic       isCall,
  input  logic       brTaken,
  input  logic       memDone,
  output logic [4:0] stepOut,
  output logic       rfWrEn,
  output logic       memRdEn,
  output logic       memWrEn,
  output logic       irLoadEn,
  output logic       pcLoadEn,
  output logic       pcSrcSel,
  output logic       bImmSel,
  output logic       maddrSel,
  output logic       wbLatchEn,
  output logic [1:0] wbSel,
  output logic [1:0] aluOp
);
  step_t stepQ;
  class_t rawClass, qualClass;
  logic illegal;
  ctrlStrobes_t strbRaw, strb;

  always_comb begin
    rawClass = '0;
    rawClass[CL_ALU] = isAlu;
    rawClass[CL_LOAD] = isLoad;
    rawClass[CL_STORE] = isStore;
    rawClass[CL_BRANCH] = isBranch;
    rawClass[CL_CALL] = isCall;
  end

  mcc_step_seq u_seq (
    .clk(clk), .rst(rst), .memDone(memDone), .stepQ(stepQ)
  );

  mcc_class_check u_cls (
    .rawClass(rawClass), .qualClass(qualClass), .illegal(illegal)
  );

  mcc_strobe_gen u_gen (
    .step(stepQ), .cls(qualClass), .brTaken(brTaken),
    .memDone(memDone), .strb(strbRaw)
  );

  // Reset silences every strobe in the same cycle it is seen.
  assign strb = rst ? '0 : strbRaw;

  assign stepOut = stepQ;
  assign rfWrEn = strb.rfWr;
  assign memRdEn = strb.memRd;
  assign memWrEn = strb.memWr;
  assign irLoadEn = strb.irLoad;
  assign pcLoadEn = strb.pcLoad;
  assign pcSrcSel = strb.pcSrc;
  assign bImmSel = strb.bImm;
  assign maddrSel = strb.maddr;
  assign wbLatchEn = strb.wbLatch;
  assign wbSel = strb.wbSel;
  assign aluOp = strb.aluOp;
endmodule

// File: rtl/mcc_control_unit_chk.sv
module mcc_control_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       isAlu,
  input logic       isLoad,
  input logic       isStore,
  input logic       isBranch,
  input logic       isCall,
  input logic       memDone,
  input logic [4:0] stepOut,
  input logic       rfWrEn,
  input logic       memRdEn,
  input logic       memWrEn,
  input logic       irLoadEn,
  input logic       pcLoadEn,
  input logic       wbLatchEn
);
  logic multiHot;
  assign multiHot = $countones({isAlu, isLoad, isStore, isBranch, isCall}) > 1;

  AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(stepOut) == 1); // R1
  AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    stepOut[0] && memDone |=> stepOut[1]); // R1
  AST_WB_WRAP: assert property (@(posedge clk) disable iff (rst)
    stepOut[4] |=> stepOut[0]); // R1
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    stepOut[0] && !memDone |=> stepOut[0]); // R2
  AST_IR_GATED: assert property (@(posedge clk) disable iff (rst)
    irLoadEn |-> stepOut[0] && memDone); // R2
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> !(rfWrEn || memRdEn || memWrEn || irLoadEn || pcLoadEn || wbLatchEn)); // R3
  AST_RF_IN_WB: assert property (@(posedge clk) disable iff (rst)
    rfWrEn |-> stepOut[4] && !isStore && !isBranch); // R4
  AST_MEMWR_STORE: assert property (@(posedge clk) disable iff (rst)
    memWrEn |-> stepOut[3] && isStore); // R6
  AST_PC_STEPS: assert property (@(posedge clk) disable iff (rst)
    pcLoadEn |-> stepOut[0] || stepOut[2]); // R7
  AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (rst)
    multiHot |-> !(rfWrEn || memWrEn || wbLatchEn || (memRdEn && !stepOut[0]))); // R11
endmodule

bind mcc_control_unit mcc_control_unit_chk u_chk (
  .clk(clk), .rst(rst), .isAlu(isAlu), .isLoad(isLoad), .isStore(isStore),
  .isBranch(isBranch), .isCall(isCall), .memDone(memDone), .stepOut(stepOut),
  .rfWrEn(rfWrEn), .memRdEn(memRdEn), .memWrEn(memWrEn), .irLoadEn(irLoadEn),
  .pcLoadEn(pcLoadEn), .wbLatchEn(wbLatchEn)
);

// File: tb/mcc_control_unit_tb.sv
module mcc_control_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic isAlu = 0, isLoad = 0, isStore = 0, isBranch = 0, isCall = 0;
  logic brTaken = 0, memDone = 0;
  logic [4:0] stepOut;
  logic rfWrEn, memRdEn, memWrEn, irLoadEn, pcLoadEn, pcSrcSel, bImmSel;
  logic maddrSel, wbLatchEn;
  logic [1:0] wbSel, aluOp;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mcc_control_unit u_dut (.*);

  // Vector: [16:12] class {call,branch,store,load,alu}, [11] taken,
  // expected [10] rf(wb) [9] memRd(mem) [8] memWr(mem) [7] pcLoad(exec)
  // [6] bImm [5:4] aluOp [3] maddr [2:1] wbSel [0] wbLatch
  localparam int NV = 9;
  localparam logic [16:0] VEC [NV] = '{
    {5'b00001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 2'd0, 1'b1}, // alu
    {5'b00010, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 2'd1, 1'b1}, // load
    {5'b00100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 2'd0, 1'b0}, // store
    {5'b01000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 2'd0, 1'b0}, // branch taken
    {5'b01000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 2'd0, 1'b0}, // branch not taken
    {5'b10000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 2'd2, 1'b1}, // call
    {5'b00011, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0}, // illegal
    {5'b00000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0}, // no class
    {5'b11000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0}  // illegal
  };

  // Observed: [12] rf [11] memRd [10] memWr [9] ir [8] pcLoad [7] pcSrc
  // [6] bImm [5:4] aluOp [3] maddr [2:1] wbSel [0] wbLatch
  function automatic logic [12:0] obs();
    return {rfWrEn, memRdEn, memWrEn, irLoadEn, pcLoadEn, pcSrcSel, bImmSel,
            aluOp, maddrSel, wbSel, wbLatchEn};
  endfunction

  task automatic chkOut(string req, logic [12:0] exp);
    total++;
    if (obs() !== exp) begin
      bad++;
      $display("FAIL %s: outputs actual=%b expected=%b", req, obs(), exp);
    end
  endtask

  task automatic chkStep(string req, logic [4:0] exp);
    total++;
    if (stepOut !== exp) begin
      bad++;
      $display("FAIL %s: stepOut actual=%b expected=%b", req, stepOut, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic setClass(logic [4:0] c);
    {isCall, isBranch, isStore, isLoad, isAlu} = c;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [12:0] e;
    logic pcs;
    // R3: reset state
    tick();
    memDone = 1'b1;
    #1;
    chkStep("R3 reset step", 5'b00001);
    chkOut("R3 outputs quiet in reset", 13'b0);
    tick();
    chkStep("R3 held in fetch during reset", 5'b00001);
    rst = 1'b0;
    memDone = 1'b0;
    #1;

    for (int v = 0; v < NV; v++) begin
      logic [16:0] t;
      t = VEC[v];
      setClass(t[16:12]);
      brTaken = t[11];
      pcs = (t[16:12] == 5'b01000) || (t[16:12] == 5'b10000);
      for (int w = 0; w < (v % 3); w++) begin
        chkStep("R2 fetch hold", 5'b00001);
        chkOut("R5 R2 fetch waiting", 13'b0100000000000);
        tick();
      end
      memDone = 1'b1;
      #1;
      chkStep("R1 fetch", 5'b00001);
      chkOut("R7 R2 fetch complete", 13'b0101100000000);
      tick();
      memDone = 1'b0;
      #1;
      chkStep("R1 decode", 5'b00010);
      chkOut("R12 decode quiet", 13'b0);
      tick();
      chkStep("R1 execute", 5'b00100);
      e = '0;
      e[8] = t[7];
      e[7] = pcs;
      e[6] = t[6];
      e[5:4] = t[5:4];
      chkOut((v >= 6) ? "R11 execute" : "R8 R7 execute", e);
      tick();
      chkStep("R1 memory", 5'b01000);
      e = '0;
      e[11] = t[9];
      e[10] = t[8];
      e[3] = t[3];
      e[2:1] = t[2:1];
      e[0] = t[0];
      chkOut((v >= 6) ? "R11 memory" : "R5 R6 R9 R10 memory", e);
      tick();
      chkStep("R1 writeback", 5'b10000);
      e = '0;
      e[12] = t[10];
      chkOut((v >= 6) ? "R11 writeback" : "R4 writeback", e);
      tick();
      chkStep("R1 wrap to fetch", 5'b00001);
    end

    // R3: reset in mid-instruction returns to fetch, outputs silent
    setClass(5'b00010);
    memDone = 1'b1;
    tick();
    memDone = 1'b0;
    tick();
    chkStep("R3 pre-reset execute", 5'b00100);
    rst = 1'b1;
    memDone = 1'b1;
    #1;
    chkOut("R3 quiet while reset high", 13'b0);
    tick();
    chkStep("R3 reset to fetch", 5'b00001);
    rst = 1'b0;
    memDone = 1'b0;
    #1;
    // R2: long fetch wait, then R12 with no class flags
    setClass(5'b00000);
    for (int w = 0; w < 6; w++) tick();
    chkStep("R2 long hold", 5'b00001);
    chkOut("R2 no ir load without memDone", 13'b0100000000000);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule